// File: doc/BRIEF.md
# Burst Column Address Generator

This block walks the column addresses of a single SDRAM read or write burst. A controller pulses a start strobe together with the first column and the current mode settings: a burst length code, a sequential or interleaved ordering bit, and a bit that limits writes to one location. From the next clock on, the block presents one column per beat. It steps to the next beat on every cycle in which the advance enable is high.

Fixed bursts of 2, 4 or 8 beats stay inside the aligned block that holds the start column. Only the low address bits move, and they wrap at the block boundary. A full-page burst steps sequentially through the whole row, wraps from the top column to column 0, and runs until it is terminated. The block flags the final beat of a fixed burst. A reserved length code produces a single-beat access and sets a sticky error flag.

Top module: `burst_col_gen`

## Requirements
- R1: After reset, `valid_o`, `last_o` and `err_o` are all 0.
- R2: On the cycle after a clock edge at which `start_i` is 1, `valid_o` is 1 and `col_o` equals the `col_i` sampled at that edge. All mode inputs are sampled at that same edge.
- R3: Length codes on `bl_code_i` set the number of beats: 3'b000 gives 1, 3'b001 gives 2, 3'b010 gives 4 and 3'b011 gives 8. After the final beat is advanced, `valid_o` is 0.
- R4: With `interleave_i`=0 and burst length L in {2,4,8}, beat k presents column `base + ((s + k) mod L)`. Here s is the start column mod L and base is the start column minus s, so the upper bits stay fixed.
- R5: With `interleave_i`=1 and burst length L in {2,4,8}, beat k presents column `base + (s XOR k)`, using the same base and s as in R4.
- R6: Code 3'b111 selects a full-page burst. It is sequential whatever `interleave_i` is, goes from column 511 to 0, continues until terminated, and never raises `last_o`.
- R7: With length 1, `interleave_i` has no effect and exactly one beat at the start column is presented.
- R8: With `wr_single_i`=1, a write (`is_write_i`=1) is one beat, while a read uses the programmed length. With `wr_single_i`=0, a write uses the programmed length.
- R9: The beat moves forward only on edges where `adv_i` is 1. Otherwise `col_o` and `valid_o` hold.
- R10: If `term_i` is 1 at an edge while `valid_o` is 1 and `start_i` is 0, `valid_o` is 0 after that edge. If `start_i` is also 1, the start takes priority.
- R11: `last_o` is 1 exactly on the final beat of a fixed-length burst and only while `valid_o` is 1.
- R12: A start with a reserved code (3'b100, 3'b101 or 3'b110) gives a one-beat burst and sets `err_o`. `err_o` then stays 1 until reset.
- R13: A start strobe during a burst restarts the sequence from the new column on the next cycle, using the new mode.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| start_i | input | 1 | Begin a burst at `col_i` |
| col_i | input | 9 | Start column |
| bl_code_i | input | 3 | Burst length code |
| interleave_i | input | 1 | 0 sequential, 1 interleaved order |
| wr_single_i | input | 1 | 1 limits writes to one location |
| is_write_i | input | 1 | 1 for a write burst, 0 for a read |
| adv_i | input | 1 | Advance to the next beat |
| term_i | input | 1 | Truncate the current burst |
| col_o | output | 9 | Current column |
| valid_o | output | 1 | A beat is being presented |
| last_o | output | 1 | Current beat is the last of a fixed burst |
| err_o | output | 1 | Sticky: a reserved length code was seen |

## Verification
Sequential bursts start in the middle of their block, so a plain incrementing counter that crosses the boundary would give a different column. Interleaved bursts use odd start offsets, where XOR and addition give different results. A full-page run starts near the top of the row, so the move from 511 to 0 is seen, and the interleave bit is set to show that it is ignored. Write-single, reserved-code, hold, terminate and restart patterns each end at a beat count or column value that would be wrong if the corresponding mode were mishandled.

// File: rtl/burst_col_gen.sv
module burst_col_gen #(
  parameter int COL_W = 9
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             start_i,
  input  logic [COL_W-1:0] col_i,
  input  logic [2:0]       bl_code_i,
  input  logic             interleave_i,
  input  logic             wr_single_i,
  input  logic             is_write_i,
  input  logic             adv_i,
  input  logic             term_i,
  output logic [COL_W-1:0] col_o,
  output logic             valid_o,
  output logic             last_o,
  output logic             err_o
);

  logic [COL_W-1:0] base_q, cnt_q, mask_q, mask_n, step;
  logic             ilv_q, full_q, full_n, rsv_n, single_n;

  assign single_n = is_write_i && wr_single_i;

  always_comb begin
    mask_n = '0;
    full_n = 1'b0;
    rsv_n  = 1'b0;
    case (bl_code_i)
      3'b000: mask_n = '0;
      3'b001: mask_n = COL_W'(1);
      3'b010: mask_n = COL_W'(3);
      3'b011: mask_n = COL_W'(7);
      3'b111: begin mask_n = '1; full_n = 1'b1; end
      default: rsv_n = 1'b1;
    endcase
    if (single_n) begin
      mask_n = '0;
      full_n = 1'b0;
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      base_q  <= '0;
      cnt_q   <= '0;
      mask_q  <= '0;
      ilv_q   <= 1'b0;
      full_q  <= 1'b0;
      valid_o <= 1'b0;
      err_o   <= 1'b0;
    end else if (start_i) begin
      base_q  <= col_i;
      cnt_q   <= '0;
      mask_q  <= mask_n;
      ilv_q   <= interleave_i && !full_n;
      full_q  <= full_n;
      valid_o <= 1'b1;
      if (rsv_n) err_o <= 1'b1;
    end else if (valid_o && term_i) begin
      valid_o <= 1'b0;
    end else if (valid_o && adv_i) begin
      if (last_o) valid_o <= 1'b0;
      else        cnt_q   <= cnt_q + 1'b1;
    end
  end

  assign step   = ilv_q ? (base_q ^ cnt_q) : (base_q + cnt_q);
  assign col_o  = (base_q & ~mask_q) | (step & mask_q);
  assign last_o = valid_o && !full_q && (cnt_q == mask_q);

endmodule

// File: rtl/burst_col_gen_chk.sv
module burst_col_gen_chk #(
  parameter int COL_W = 9
) (
  input logic             clk,
  input logic             rst_n,
  input logic             start_i,
  input logic [COL_W-1:0] col_i,
  input logic             adv_i,
  input logic             term_i,
  input logic [COL_W-1:0] col_o,
  input logic             valid_o,
  input logic             last_o,
  input logic             err_o
);

  a_r2_start_loads: assert property (@(posedge clk) disable iff (!rst_n)
    start_i |=> (valid_o && col_o == $past(col_i)));

  a_r9_hold_beat: assert property (@(posedge clk) disable iff (!rst_n)
    (valid_o && !adv_i && !start_i && !term_i) |=> (valid_o && $stable(col_o)));

  a_r10_term_stops: assert property (@(posedge clk) disable iff (!rst_n)
    (valid_o && term_i && !start_i) |=> !valid_o);

  a_r11_last_in_burst: assert property (@(posedge clk) disable iff (!rst_n)
    last_o |-> valid_o);

  a_r11_last_ends: assert property (@(posedge clk) disable iff (!rst_n)
    (last_o && adv_i && !start_i) |=> !valid_o);

  a_r12_err_sticky: assert property (@(posedge clk) disable iff (!rst_n)
    err_o |=> err_o);

endmodule

bind burst_col_gen burst_col_gen_chk #(.COL_W(COL_W)) chk_i (
  .clk(clk), .rst_n(rst_n), .start_i(start_i), .col_i(col_i),
  .adv_i(adv_i), .term_i(term_i), .col_o(col_o), .valid_o(valid_o),
  .last_o(last_o), .err_o(err_o)
);

// File: tb/burst_col_gen_tb_top.sv
module burst_col_gen_tb_top;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       start_i = 1'b0;
  logic [8:0] col_i = '0;
  logic [2:0] bl_code_i = '0;
  logic       interleave_i = 1'b0, wr_single_i = 1'b0, is_write_i = 1'b0;
  logic       adv_i = 1'b0, term_i = 1'b0;
  logic [8:0] col_o;
  logic       valid_o, last_o, err_o;
  int total = 0, bad = 0;

  always #2.5 clk = ~clk;

  burst_col_gen dut_i (.*);

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s act=%0d exp=%0d", tag, act, exp);
    end
  endtask

  task automatic tick();
    @(posedge clk); #1;
  endtask

  function automatic int expc(int s, int len, bit ilv, int k);
    int lo = s % len;
    int base = s - lo;
    return ilv ? base + (lo ^ k) : base + ((lo + k) % len);
  endfunction

  task automatic do_start(int col, int code, bit ilv, bit wrs, bit wr);
    col_i = col[8:0]; bl_code_i = code[2:0]; interleave_i = ilv;
    wr_single_i = wrs; is_write_i = wr; start_i = 1'b1;
    tick();
    start_i = 1'b0;
  endtask

  task automatic run_fixed(string tag, int col, int code, bit ilv, bit wrs, bit wr,
                           int len, bit ilv_exp);
    do_start(col, code, ilv, wrs, wr);
    adv_i = 1'b1;
    for (int k = 0; k < len; k++) begin
      int e = expc(col, len, ilv_exp, k);
      chk(valid_o, {tag, " R2 valid"}, valid_o, 1);
      chk(col_o == e[8:0], {tag, " col"}, col_o, e);
      chk(last_o == (k == len - 1), {tag, " R11 last"}, last_o, k == len - 1);
      tick();
    end
    chk(!valid_o, {tag, " R3 end"}, valid_o, 0);
    adv_i = 1'b0;
  endtask

  task automatic t_reset();
    chk(!valid_o && !last_o && !err_o, "R1 reset", {valid_o, last_o, err_o}, 0);
  endtask

  task automatic t_seq();
    run_fixed("R4 seq4", 2, 3'b010, 0, 0, 0, 4, 0);
    run_fixed("R4 seq8", 13, 3'b011, 0, 0, 0, 8, 0);
    run_fixed("R4 seq2", 7, 3'b001, 0, 0, 0, 2, 0);
  endtask

  task automatic t_ilv();
    run_fixed("R5 ilv8", 1, 3'b011, 1, 0, 0, 8, 1);
    run_fixed("R5 ilv4", 423, 3'b010, 1, 0, 0, 4, 1);
    run_fixed("R5 ilv2", 255, 3'b001, 1, 0, 0, 2, 1);
  endtask

  task automatic t_len1();
    run_fixed("R7 len1", 300, 3'b000, 1, 0, 0, 1, 0);
  endtask

  task automatic t_wrs();
    run_fixed("R8 wr single", 45, 3'b011, 0, 1, 1, 1, 0);
    run_fixed("R8 rd burst", 45, 3'b011, 0, 1, 0, 8, 0);
    run_fixed("R8 wr burst", 45, 3'b010, 0, 0, 1, 4, 0);
  endtask

  task automatic t_full();
    do_start(500, 3'b111, 1, 0, 0);
    adv_i = 1'b1;
    for (int k = 0; k < 520; k++) begin
      int e = (500 + k) % 512;
      chk(valid_o && col_o == e[8:0], "R6 full col", col_o, e);
      chk(!last_o, "R6 full no last", last_o, 0);
      tick();
    end
    term_i = 1'b1;
    tick();
    term_i = 1'b0; adv_i = 1'b0;
    chk(!valid_o, "R10 full term", valid_o, 0);
  endtask

  task automatic t_hold();
    do_start(5, 3'b011, 0, 0, 0);
    for (int k = 0; k < 3; k++) begin
      tick();
      chk(valid_o && col_o == 5, "R9 hold", col_o, 5);
    end
    adv_i = 1'b1;
    tick();
    adv_i = 1'b0;
    chk(col_o == 6, "R9 advance", col_o, 6);
  endtask

  task automatic t_term();
    do_start(0, 3'b011, 0, 0, 0);
    adv_i = 1'b1;
    tick(); tick();
    chk(col_o == 2, "R10 pre term", col_o, 2);
    adv_i = 1'b0; term_i = 1'b1;
    tick();
    term_i = 1'b0;
    chk(!valid_o && !last_o, "R10 term", valid_o, 0);
  endtask

  task automatic t_restart();
    do_start(0, 3'b011, 0, 0, 0);
    adv_i = 1'b1;
    tick(); tick(); tick();
    run_fixed("R13 restart", 100, 3'b001, 0, 0, 0, 2, 0);
    do_start(8, 3'b011, 0, 0, 0);
    col_i = 9'd33; bl_code_i = 3'b010; term_i = 1'b1; start_i = 1'b1;
    tick();
    start_i = 1'b0; term_i = 1'b0;
    chk(valid_o && col_o == 33, "R10 start over term", col_o, 33);
    term_i = 1'b1;
    tick();
    term_i = 1'b0;
  endtask

  task automatic t_rsv();
    do_start(77, 3'b101, 1, 0, 0);
    chk(valid_o && col_o == 77 && last_o, "R12 rsv one beat", col_o, 77);
    chk(err_o, "R12 err set", err_o, 1);
    adv_i = 1'b1;
    tick();
    adv_i = 1'b0;
    chk(!valid_o, "R12 rsv end", valid_o, 0);
    run_fixed("R12 after", 10, 3'b010, 0, 0, 0, 4, 0);
    chk(err_o, "R12 err sticky", err_o, 1);
  endtask

  initial begin
    fork
      begin
        tick(); tick();
        t_reset();
        rst_n = 1'b1;
        tick();
        t_reset();
        t_seq();
        t_ilv();
        t_len1();
        t_wrs();
        t_full();
        t_hold();
        t_term();
        t_restart();
        t_rsv();
      end
      begin
        repeat (20000) @(posedge clk);
        total++; bad++;
        $display("FAIL watchdog act=0 exp=1");
      end
    join_any
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule